// File: doc/BRIEF.md
# Conflict-Free Bank Address Generator for a Memory-Based FFT

This block drives the memory side of an in-place FFT engine that moves sixteen complex samples per cycle between two sets of sixteen single-port banks. After a start pulse with a transform length between 32 and 2048 points, it runs through the stages. All radix-4 stages come first. A single radix-2 stage follows when the length is an odd power of two. Each stage reads one bank set and writes the other. For each issued cycle the block outputs sixteen bank numbers and sixteen in-bank addresses.

A sample with index n is stored in bank (sum of the base-16 digits of n) mod 16, at word n >> 4. In each cycle the sixteen lanes take the indices that differ only in a four-bit window of the index. That window is placed so that it holds the butterfly bits of the current stage. This makes the sixteen banks distinct, and every cycle carries whole butterflies. A registered select vector tells the butterfly side which bank each lane reads. When the last stage finishes, a done pulse reports which bank set holds the result.

Top module: `fft_bank_agen`

## Requirements
- R1: After reset, busy and done are 0, rd_set is 0, and every xbar_sel entry is 0.
- R2: A start pulse while idle begins a transform only if log2_size is between 5 and 11 inclusive. With any other value, busy stays 0.
- R3: While busy, the sixteen bank_idx lanes are pairwise distinct. Lane i accesses sample n = bank_addr[i]*16 + lo, where lo satisfies bank_idx[i] = (sum of base-16 digits of n) mod 16.
- R4: A cycle is issued when busy and ready are both 1. Each stage takes exactly N/16 issued cycles. While ready is 0, all address outputs hold their values.
- R5: A transform of 2^L points has floor(L/2) radix-4 stages (radix4=1), followed by one radix-2 stage (radix4=0) when L is odd.
- R6: rd_set is 0 in the first stage and toggles at every stage boundary. The write set is its complement.
- R7: Within a stage, every sample index 0..N-1 is accessed exactly once. Each cycle holds complete butterflies. In radix-4 stage s, the butterfly partners differ in bits L-2-2s and L-1-2s. In the radix-2 stage, the partners differ in bit 0.
- R8: One cycle after an issued cycle, xbar_sel[i] equals the bank_idx[i] of that issue. Without an issue, xbar_sel holds its value.
- R9: done is 1 for exactly one cycle, the cycle after the final issue, and busy is 0 in that cycle. result_set equals the set written by the last stage: 1 when the stage count is odd, 0 otherwise.
- R10: A start pulse while busy has no effect. The running transform keeps its length and its completion timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| log2_size | input | 4 | Log2 of the transform length, sampled at start |
| ready | input | 1 | Datapath accepts the current access |
| busy | output | 1 | Transform in progress, address outputs valid |
| rd_set | output | 1 | Bank set being read (writes go to the other set) |
| radix4 | output | 1 | Current stage is radix-4 |
| bank_idx | output | 16x4 | Bank number per lane |
| bank_addr | output | 16x7 | Word address inside the bank per lane |
| xbar_sel | output | 16x4 | Registered bank select per butterfly lane |
| done | output | 1 | One-cycle completion pulse |
| result_set | output | 1 | Bank set holding the result |

## Verification
The assertions assume that start is a single-cycle pulse and that ready changes only between clock edges. They also assume that log2_size is stable in the cycle that start is sampled. The bench drives every input at the falling edge and keeps start high for one cycle. It tests lengths out of range only at the start pulse. The bench rebuilds each lane's sample index from the bank and address outputs. It then checks coverage and butterfly grouping against the stage order it computes itself. It also varies the ready pattern so that stalls fall in the middle of stages and at stage boundaries.

// File: rtl/fft_agen_pkg.sv
package fft_agen_pkg;
    localparam int LANES    = 16;
    localparam int BANK_W   = 4;
    localparam int MAX_LOG2 = 11;
    localparam int MIN_LOG2 = 5;
    localparam int IDX_W    = MAX_LOG2;
    localparam int ADDR_W   = MAX_LOG2 - BANK_W;
    localparam int LOG_W    = 4;
    localparam int STG_W    = 3;
    localparam int DIGITS   = (IDX_W + BANK_W - 1) / BANK_W;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
    } lane_acc_t;

    // digit-sum skew: bank of a sample index
    function automatic logic [BANK_W-1:0] bank_of(input logic [IDX_W-1:0] n);
        logic [BANK_W-1:0] acc;
        acc = '0;
        for (int d = 0; d < DIGITS; d++)
            acc = acc + BANK_W'(n >> (d * BANK_W));
        return acc;
    endfunction

    // place a 4-bit lane value at bit w of the cycle count
    function automatic logic [IDX_W-1:0] spread(input logic [ADDR_W-1:0] cyc,
                                                input logic [LOG_W-1:0]  w,
                                                input logic [BANK_W-1:0] lane);
        logic [IDX_W-1:0] c, lowm;
        c    = IDX_W'(cyc);
        lowm = (IDX_W'(1) << w) - IDX_W'(1);
        return ((c & ~lowm) << BANK_W) | (IDX_W'(lane) << w) | (c & lowm);
    endfunction
endpackage

// File: rtl/fft_agen_seq.sv
module fft_agen_seq
    import fft_agen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LOG_W-1:0]  log2_size,
    input  logic              ready,
    output logic              busy,
    output logic              issue,
    output logic [ADDR_W-1:0] cyc,
    output logic [LOG_W-1:0]  win,
    output logic              rd_set,
    output logic              radix4,
    output logic              done,
    output logic              result_set
);
    seq_state_t       st;
    logic [LOG_W-1:0] len_r;
    logic [STG_W-1:0] stage;
    logic [LOG_W-1:0] n_r4, n_stg, bpos, len_m4;
    logic [ADDR_W-1:0] cyc_last;
    logic             last_cyc, last_stg, legal;

    always_comb begin
        n_r4     = len_r >> 1;
        n_stg    = (len_r + LOG_W'(1)) >> 1;
        radix4   = LOG_W'(stage) < n_r4;
        bpos     = radix4 ? (len_r - LOG_W'(2) - (LOG_W'(stage) << 1)) : '0;
        len_m4   = len_r - LOG_W'(4);
        win      = (bpos < len_m4) ? bpos : len_m4;
        cyc_last = ADDR_W'((32'd1 << len_m4) - 32'd1);
        last_cyc = (cyc == cyc_last);
        last_stg = (LOG_W'(stage) == n_stg - LOG_W'(1));
        busy     = (st == SEQ_RUN);
        issue    = busy && ready;
        rd_set   = stage[0];
        legal    = (log2_size >= LOG_W'(MIN_LOG2)) && (log2_size <= LOG_W'(MAX_LOG2));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SEQ_IDLE;
            len_r      <= LOG_W'(MIN_LOG2);
            stage      <= '0;
            cyc        <= '0;
            done       <= 1'b0;
            result_set <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SEQ_IDLE: if (start && legal) begin
                    st    <= SEQ_RUN;
                    len_r <= log2_size;
                    stage <= '0;
                    cyc   <= '0;
                end
                default: if (ready) begin
                    if (last_cyc) begin
                        cyc <= '0;
                        if (last_stg) begin
                            st         <= SEQ_IDLE;
                            done       <= 1'b1;
                            result_set <= ~stage[0];
                        end else begin
                            stage <= stage + STG_W'(1);
                        end
                    end else begin
                        cyc <= cyc + ADDR_W'(1);
                    end
                end
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                  // R9
    AST_RADIX_ORDER: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && !$past(radix4) |-> !radix4);                // R5
    AST_SET_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && (rd_set != $past(rd_set)) |-> cyc == '0);   // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy && !ready) |-> $stable(cyc) && $stable(stage)); // R4
    AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(len_r));                           // R10
endmodule

// File: rtl/fft_agen_lane.sv
module fft_agen_lane
    import fft_agen_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic [ADDR_W-1:0] cyc,
    input  logic [LOG_W-1:0]  win,
    output lane_acc_t         acc
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx      = spread(cyc, win, BANK_W'(LANE));
        acc.bank = bank_of(idx);
        acc.addr = idx[IDX_W-1:BANK_W];
    end
endmodule

// File: rtl/fft_agen_xbar.sv
module fft_agen_xbar
    import fft_agen_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          issue,
    input  logic [LANES-1:0][BANK_W-1:0]  bank_in,
    output logic [LANES-1:0][BANK_W-1:0]  sel
);
    always_ff @(posedge clk) begin
        if (rst)        sel <= '0;
        else if (issue) sel <= bank_in;
    end

    AST_XBAR_LATENCY: assert property (@(posedge clk) disable iff (rst)
        issue |=> sel == $past(bank_in));                                 // R8
    AST_XBAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(sel));                                         // R8
endmodule

// File: rtl/fft_bank_agen.sv
module fft_bank_agen
    import fft_agen_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [LOG_W-1:0]              log2_size,
    input  logic                          ready,
    output logic                          busy,
    output logic                          rd_set,
    output logic                          radix4,
    output logic [LANES-1:0][BANK_W-1:0]  bank_idx,
    output logic [LANES-1:0][ADDR_W-1:0]  bank_addr,
    output logic [LANES-1:0][BANK_W-1:0]  xbar_sel,
    output logic                          done,
    output logic                          result_set
);
    logic              issue;
    logic [ADDR_W-1:0] cyc;
    logic [LOG_W-1:0]  win;
    lane_acc_t         acc [LANES];
    logic [LANES-1:0]  hit;

    fft_agen_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .log2_size(log2_size),
        .ready(ready), .busy(busy), .issue(issue), .cyc(cyc), .win(win),
        .rd_set(rd_set), .radix4(radix4), .done(done), .result_set(result_set)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fft_agen_lane #(.LANE(g)) u_lane (.cyc(cyc), .win(win), .acc(acc[g]));
        assign bank_idx[g]  = acc[g].bank;
        assign bank_addr[g] = acc[g].addr;
    end

    fft_agen_xbar u_xbar (
        .clk(clk), .rst(rst), .issue(issue), .bank_in(bank_idx), .sel(xbar_sel)
    );

    always_comb begin
        hit = '0;
        for (int i = 0; i < LANES; i++) hit[bank_idx[i]] = 1'b1;
    end

    AST_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        busy |-> $countones(hit) == LANES);                               // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                  // R9
endmodule

// File: tb/sim_fft_bank_agen.sv
module sim_fft_bank_agen;
    import fft_agen_pkg::*;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, ready = 1'b0;
    logic [LOG_W-1:0] log2_size = '0;
    logic busy, rd_set, radix4, done, result_set;
    logic [LANES-1:0][BANK_W-1:0] bank_idx, xbar_sel;
    logic [LANES-1:0][ADDR_W-1:0] bank_addr;
    int n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    fft_bank_agen u0 (
        .clk(clk), .rst(rst), .start(start), .log2_size(log2_size), .ready(ready),
        .busy(busy), .rd_set(rd_set), .radix4(radix4), .bank_idx(bank_idx),
        .bank_addr(bank_addr), .xbar_sel(xbar_sel), .done(done), .result_set(result_set)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sample_of(input int lane);
        int a, ds;
        a  = int'(bank_addr[lane]);
        ds = (a & 15) + ((a >> 4) & 15);
        return a * 16 + ((int'(bank_idx[lane]) - ds) & 15);
    endfunction

    task automatic run_fft(input int L, input int pat, input bit poke);
        int n_pts = 1 << L, per = 1 << (L - 4), n_st = (L + 1) / 2;
        int issues = 0, k = 0, st, last_st = -1, b, cnt = 0, bad;
        bit pissue = 0;
        logic [LANES-1:0][BANK_W-1:0] pb;
        bit [2047:0] seen, cur;
        logic [LANES-1:0] hits;
        @(negedge clk);
        start = 1'b1; log2_size = LOG_W'(L); ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 legal start", int'(busy), 1);
        pb = bank_idx;
        while (issues < n_st * per) begin
            st = issues / per;
            if (st != last_st) begin seen = '0; cnt = 0; last_st = st; end
            if (pissue) chk(xbar_sel == pb, "R8 xbar latency", int'(xbar_sel[0]), int'(pb[0]));
            else if (k > 0) chk(bank_idx == pb, "R4 stall hold", int'(bank_idx[0]), int'(pb[0]));
            hits = '0;
            for (int i = 0; i < LANES; i++) hits[bank_idx[i]] = 1'b1;
            chk(&hits, "R3 distinct banks", $countones(hits), LANES);
            chk(radix4 == (st < L / 2), "R5 radix", int'(radix4), int'(st < L / 2));
            chk(rd_set == st[0], "R6 read set", int'(rd_set), st & 1);
            cur = '0;
            for (int i = 0; i < LANES; i++) cur[sample_of(i)] = 1'b1;
            b = (st < L / 2) ? (L - 2 - 2 * st) : 0;
            bad = 0;
            for (int i = 0; i < LANES; i++) begin
                int n = sample_of(i);
                if (n >= n_pts) bad++;
                if (st < L / 2) begin
                    for (int m = 1; m < 4; m++) if (!cur[n ^ (m << b)]) bad++;
                end else if (!cur[n ^ 1]) bad++;
            end
            chk(bad == 0, "R7 butterfly group", bad, 0);
            ready = (pat == 0) || (k % pat != pat - 1);
            start = poke && (k == 5);
            if (poke && k == 5) log2_size = LOG_W'(MIN_LOG2);
            pissue = ready; pb = bank_idx;
            if (ready) begin
                bad = 0;
                for (int i = 0; i < LANES; i++) begin
                    int n = sample_of(i);
                    if (seen[n]) bad++;
                    seen[n] = 1'b1;
                end
                cnt += LANES - bad;
                issues++;
                if (issues % per == 0)
                    chk(cnt == n_pts, "R7 stage coverage", cnt, n_pts);
            end
            @(negedge clk);
            k++;
        end
        ready = 1'b0; start = 1'b0;
        chk(xbar_sel == pb, "R8 xbar last", int'(xbar_sel[0]), int'(pb[0]));
        chk(done == 1'b1, poke ? "R10 done timing" : "R9 done", int'(done), 1);
        chk(busy == 1'b0, "R9 idle at done", int'(busy), 0);
        chk(result_set == n_st[0], "R9 result set", int'(result_set), n_st & 1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single", int'(done), 0);
        chk(busy == 1'b0, poke ? "R10 no restart" : "R4 stage count", int'(busy), 0);
    endtask

    task automatic bad_size(input int L);
        @(negedge clk);
        start = 1'b1; log2_size = LOG_W'(L);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R2 illegal size ignored", int'(busy), 0);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R2 still idle", int'(busy), 0);
    endtask

    task automatic reset_check();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(rd_set == 1'b0, "R1 rd_set", int'(rd_set), 0);
        chk(xbar_sel == '0, "R1 xbar", int'(xbar_sel[0]), 0);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        reset_check();
        run_fft(5, 0, 0);
        run_fft(6, 3, 0);
        run_fft(11, 0, 0);
        run_fft(8, 2, 1);
        run_fft(7, 0, 0);
        run_fft(9, 5, 0);
        run_fft(10, 4, 0);
        bad_size(4);
        bad_size(12);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule